// File: doc/BRIEF.md
# Infrared Carrier Transmit Modulator

This block turns a stream of mark/space symbols into a modulated infrared drive signal. Software, or a neighbouring engine, pushes symbol bytes into a small transmit queue. Each byte names a level and a length. A mark byte lets a square-wave carrier through to the emitter pin. A space byte holds the pin low. The length of each symbol is counted in sample periods, which arrive as single-cycle `sample_tick` strobes from a shared timebase.

The carrier is derived from a 3 MHz reference that reaches the block as a single-cycle `ref_tick` enable. A programmable divide count `carrier_div` sets the carrier frequency to 3 MHz / (`carrier_div` + 1). The high phase lasts ceil((`carrier_div` + 1) / 2) reference ticks and the low phase takes the remainder. The carrier phase restarts at the beginning of every mark symbol, so each burst opens on a high phase.

Three status flags report the state of the queue: queue empty, queue at or below the refill level, and underrun. The underrun flag marks the end of a transmission, when a symbol finishes and no further byte is waiting. A clear strobe empties the queue and aborts the symbol in flight.

The control state machine has three states:
- `ST_IDLE`: the output is low.
- `ST_MARK`: a symbol with the carrier gated on.
- `ST_SPACE`: a symbol with the output low.

Its transitions are:
- START: IDLE to MARK or SPACE, when the queue is non-empty.
- CHAIN: MARK or SPACE to MARK or SPACE, when a symbol ends and a byte is waiting.
- DRAIN: MARK or SPACE to IDLE, when a symbol ends with the queue empty. This transition raises underrun.
- ABORT: any state to IDLE, on `fifo_clr`.

Top module: `irtx_modulator`

## Requirements
- R1: Symbols are sent in the order written. When the queue becomes non-empty in ST_IDLE, the first byte is taken on the next clock edge. When a symbol ends with a byte waiting, the next symbol begins on that same edge, with no idle gap.
- R2: A byte with bit 7 clear is a space. For the whole of its length, and in ST_IDLE, `ir_out` is 0.
- R3: A byte with bit 7 set is a mark. During a mark, `ir_out` follows a carrier with period (`carrier_div` + 1) `ref_tick` strobes. The carrier is high for ceil((`carrier_div` + 1)/2) strobes and low for the rest. With `carrier_div` = 0, the carrier stays high.
- R4: Bits 6..0 give the symbol length in `sample_tick` strobes, counted from the first strobe after the symbol starts. A length of 0 is treated as 1.
- R5: `tx_status[1]` (underrun) is set when a symbol ends with the queue empty, and `ir_out` returns to 0. The flag is cleared by any write or by `fifo_clr`.
- R6: After reset, `ir_out` = 0 and `tx_status` = 8'h0C.
- R7: `tx_status[3]` is 1 while the queue holds no byte. `tx_status[2]` is 1 while the queue holds at most `trig_level` bytes. Bits 7..4 and 0 read 0.
- R8: `fifo_clr` empties the queue, clears underrun and forces ST_IDLE on the next edge, so `ir_out` is 0 two cycles after the strobe. The removed bytes are never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the 3 MHz carrier reference rate |
| sample_tick | input | 1 | One-cycle strobe at the symbol sample period |
| carrier_div | input | DIV_W | Carrier divide count; the carrier runs at reference/(count+1) |
| trig_level | input | CW | Refill level compared against the queue occupancy |
| wr_en | input | 1 | Push `wr_data` into the queue (dropped when full) |
| wr_data | input | 8 | Symbol byte: bit 7 = mark, bits 6..0 = length |
| fifo_clr | input | 1 | Empty the queue and abort transmission |
| ir_out | output | 1 | Modulated emitter drive |
| tx_status | output | 8 | bit 3 empty, bit 2 at/below refill level, bit 1 underrun |

## Verification
The bench measures the number of sample strobes between successive burst starts. A design that left an idle cycle between chained symbols, or that counted the first strobe before the symbol began, would lengthen or shorten every interval by one. A zero-length mark must last exactly one strobe. A design that wrapped the counter would instead hold the burst for 128 strobes. Carrier high and low run lengths are measured for even, odd and zero divide counts, and for a reference slower than the clock. An off-by-one in the half-period rounding shows up there as a 3/1 or 2/3 split. The bench also checks that a clear mid-burst kills the output and discards the queued bytes, and that the refill flag switches between 8 and 9 queued bytes.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } irtx_state_e;

    localparam int SYM_W    = 8;
    localparam int LEN_W    = 7;
    localparam int MARK_POS = 7;

    // status bit positions decoded by the host side
    localparam int STS_EMPTY_POS = 3;
    localparam int STS_TRIG_POS  = 2;
    localparam int STS_UNDR_POS  = 1;

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count != CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_ok)  rptr <= rptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             carrier
);
    logic [DIV_W-1:0] phase;
    logic [DIV_W:0]   half;

    // high phase length rounded up: ceil((div+1)/2)
    assign half    = ({1'b0, div} + (DIV_W+1)'(2)) >> 1;
    assign carrier = ({1'b0, phase} < half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= '0;
        else if (restart)      phase <= '0;
        else if (ref_tick)     phase <= (phase >= div) ? '0 : phase + DIV_W'(1);
    end
endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator
    import irtx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             sample_tick,
    input  logic [DIV_W-1:0] carrier_div,
    input  logic [CW-1:0]    trig_level,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             fifo_clr,
    output logic             ir_out,
    output logic [7:0]       tx_status
);
    irtx_state_e      state_q, state_d;
    logic [SYM_W-1:0] head;
    logic [CW-1:0]    fill;
    logic             q_empty, active, sym_end, fetch, load_mark;
    logic [LEN_W-1:0] remain_q, head_len;
    logic             carrier, undr_q;

    irtx_fifo #(.DEPTH(FIFO_DEPTH), .W(SYM_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(wr_en), .din(wr_data),
        .pop(fetch), .dout(head), .count(fill)
    );

    irtx_carrier #(.DIV_W(DIV_W)) u_car (
        .clk(clk), .rst_n(rst_n), .restart(load_mark),
        .ref_tick(ref_tick), .div(carrier_div), .carrier(carrier)
    );

    assign q_empty   = (fill == '0);
    assign active    = (state_q != ST_IDLE);
    assign sym_end   = active && sample_tick && (remain_q == LEN_W'(1));
    assign fetch     = !fifo_clr && !q_empty && (!active || sym_end);
    assign load_mark = fetch && head[MARK_POS];
    assign head_len  = (head[LEN_W-1:0] == '0) ? LEN_W'(1) : head[LEN_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch) state_d = head[MARK_POS] ? ST_MARK : ST_SPACE;
            end
            ST_MARK, ST_SPACE: begin
                if (sym_end) begin
                    if (fetch) state_d = head[MARK_POS] ? ST_MARK : ST_SPACE;
                    else       state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fifo_clr) state_d = ST_IDLE;
    end

    // state register and symbol length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (fetch)                    remain_q <= head_len;
            else if (active && sample_tick) remain_q <= remain_q - LEN_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_out <= 1'b0;
            undr_q <= 1'b0;
        end else begin
            ir_out <= (state_q == ST_MARK) && carrier && !fifo_clr;
            if (fifo_clr)                 undr_q <= 1'b0;
            else if (sym_end && q_empty)  undr_q <= 1'b1;
            else if (wr_en)               undr_q <= 1'b0;
        end
    end

    always_comb begin
        tx_status                = '0;
        tx_status[STS_EMPTY_POS] = q_empty;
        tx_status[STS_TRIG_POS]  = (fill <= trig_level);
        tx_status[STS_UNDR_POS]  = undr_q;
    end
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker
    import irtx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_clr,
    input logic        ir_out,
    input logic        sts_empty,
    input logic        sts_trig,
    input logic        sts_undr,
    input irtx_state_e state
);
    // R1: a waiting byte always leaves ST_IDLE on the next edge
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sts_empty && !fifo_clr) |=> (state != ST_IDLE));

    // R5: underrun only when the queue was empty, and the output then goes low
    assert_undr_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_undr) |-> $past(sts_empty));
    assert_undr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_undr) |=> !ir_out);

    // R7: an empty queue is always at or below the refill level
    assert_empty_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_empty |-> sts_trig);

    // R8: clear empties the queue and silences the output
    assert_clr_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> sts_empty && !sts_undr);
    assert_clr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> ##1 !ir_out);
endmodule

bind irtx_modulator irtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .ir_out(ir_out),
    .sts_empty(tx_status[3]), .sts_trig(tx_status[2]),
    .sts_undr(tx_status[1]), .state(state_q)
);

// File: tb/tb_irtx_modulator.sv
module tb_irtx_modulator;
    localparam int SP = 16;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ref_tick = 1'b0, sample_tick = 1'b0;
    logic [7:0] carrier_div = 8'd3;
    logic [4:0] trig_level = 5'd8;
    logic       wr_en = 1'b0, fifo_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ir_out;
    logic [7:0] tx_status;

    int checks = 0, errors = 0;
    int exp_q[$];
    bit sample_en = 1'b0;
    int ref_every = 1;

    always #5 clk = ~clk;

    irtx_modulator dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sample_tick(sample_tick),
        .carrier_div(carrier_div), .trig_level(trig_level), .wr_en(wr_en),
        .wr_data(wr_data), .fifo_clr(fifo_clr), .ir_out(ir_out), .tx_status(tx_status)
    );

    // strobe generators, driven on the falling edge
    int sp_cnt = 0, ref_cnt = 0;
    always @(negedge clk) begin
        sample_tick <= sample_en && (sp_cnt == 0);
        sp_cnt      <= (sp_cnt == SP - 1) ? 0 : sp_cnt + 1;
        ref_tick    <= (ref_cnt == 0);
        ref_cnt     <= (ref_cnt >= ref_every - 1) ? 0 : ref_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: sample strobes between burst starts, and up to underrun
    int  cnt = 0, low_run = 100;
    bit  armed = 1'b0, prev_out = 1'b0, prev_undr = 1'b0;
    always @(posedge clk) begin
        #2;
        if (fifo_clr) armed = 1'b0;
        if (ir_out && !prev_out && low_run >= 6) begin
            if (armed) begin
                if (exp_q.size() == 0) check(1'b0, "R4 interval (queue empty)", cnt, -1);
                else begin
                    automatic int e = exp_q.pop_front();
                    check(cnt == e, "R4 mark-to-mark interval", cnt, e);
                end
            end
            armed = 1'b1;
            cnt = 0;
        end
        if (sample_tick) cnt++;
        if (tx_status[1] && !prev_undr && armed) begin
            if (exp_q.size() == 0) check(1'b0, "R5 final interval (queue empty)", cnt, -1);
            else begin
                automatic int e = exp_q.pop_front();
                check(cnt == e, "R5 final interval before underrun", cnt, e);
            end
            armed = 1'b0;
        end
        low_run   = ir_out ? 0 : low_run + 1;
        prev_out  = ir_out;
        prev_undr = tx_status[1];
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // driver: writes a train and queues the expected intervals
    task automatic send_train(input logic [7:0] bytes[]);
        int  acc = 0;
        bit  prev_mark = 1'b0;
        foreach (bytes[i]) begin
            int len = (bytes[i][6:0] == 0) ? 1 : int'(bytes[i][6:0]);
            if (bytes[i][7] && !prev_mark && i != 0) begin
                exp_q.push_back(acc);
                acc = 0;
            end
            acc += len;
            prev_mark = bytes[i][7];
        end
        exp_q.push_back(acc);
        foreach (bytes[i]) put(bytes[i]);
    endtask

    task automatic wait_undr();
        while (!tx_status[1]) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int eh, input int el, input string tag);
        int h = 0, l = 0;
        while (ir_out)  @(negedge clk);
        while (!ir_out) @(negedge clk);
        while (ir_out)  begin h++; @(negedge clk); end
        while (!ir_out) begin l++; @(negedge clk); end
        check(h == eh, {tag, " high run"}, h, eh);
        check(l == el, {tag, " low run"}, l, el);
    endtask

    task automatic abort();
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check(ir_out == 1'b0, "R6 ir_out after reset", ir_out, 0);
        check(tx_status == 8'h0C, "R6 status after reset", tx_status, 8'h0C);

        // R1 R2 R4 chained train, then R5 underrun
        sample_en = 1'b1;
        send_train('{8'h83, 8'h02, 8'h81, 8'h04});
        wait_undr();
        check(tx_status[1] == 1'b1, "R5 underrun set", tx_status[1], 1);
        check(ir_out == 1'b0, "R5 output idle after underrun", ir_out, 0);

        // R4 zero length counts as one strobe
        send_train('{8'h80, 8'h01, 8'h82});
        wait_undr();

        // R2 space-only train never drives the output
        begin
            int hi = 0;
            put(8'h03);
            while (!tx_status[1]) begin if (ir_out) hi++; @(negedge clk); end
            check(hi == 0, "R2 output during space", hi, 0);
        end

        // R5 write clears underrun; hold a mark (no sample strobes)
        sample_en = 1'b0;
        repeat (2) @(negedge clk);
        put(8'h85);
        repeat (3) @(negedge clk);
        check(tx_status[1] == 1'b0, "R5 underrun cleared by write", tx_status[1], 0);

        // R3 carrier shapes
        measure(2, 2, "R3 div3");
        abort();
        carrier_div = 8'd4; put(8'h85);
        measure(3, 2, "R3 div4");
        abort();
        carrier_div = 8'd1; ref_every = 2; put(8'h85);
        measure(2, 2, "R3 div1 slow ref");
        abort();
        carrier_div = 8'd0; ref_every = 1; put(8'h85);
        repeat (4) @(negedge clk);
        begin
            int lo = 0;
            repeat (40) begin if (!ir_out) lo++; @(negedge clk); end
            check(lo == 0, "R3 div0 constant high", lo, 0);
        end

        // R7 fill flags with the mark held
        carrier_div = 8'd3;
        repeat (8) put(8'h01);
        @(negedge clk);
        check(tx_status == 8'h04, "R7 eight queued", tx_status, 8'h04);
        put(8'h01);
        @(negedge clk);
        check(tx_status == 8'h00, "R7 nine queued", tx_status, 8'h00);

        // R8 clear aborts and discards
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        check(tx_status == 8'h0C, "R8 status after clear", tx_status, 8'h0C);
        @(negedge clk);
        check(ir_out == 1'b0, "R8 output after clear", ir_out, 0);
        sample_en = 1'b1;
        begin
            int hi = 0;
            repeat (300) begin if (ir_out) hi++; @(negedge clk); end
            check(hi == 0, "R8 discarded bytes not sent", hi, 0);
        end

        check(exp_q.size() == 0, "R1 all expected intervals seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule